// File: doc/BRIEF.md
# Banked Control Register File

This block is the control-register unit of a processor core. It keeps the status word and its saved copies, the condition bit, two saved program counters, two general storage words (one used as the exception vector base), and the two stack-pointer shadows that trade places with the live stack pointer, general register 15. Software and trap logic reach these registers through one read port and one write port, both indexed by a 4-bit control-register number. The read port is combinational. A write takes effect at the next rising clock edge.

The rest of the general register file keeps a side path to register 15. It can read the live stack pointer at any time and can write it. The condition bit and the stack mode are exposed as plain outputs for the execute stage.

The block has no data stream, so every port is a plain control or data pin with no valid/ready handshake. The write ports have no back-pressure: every enabled write is taken at the next edge.

When a status-word write changes the stack-mode bit, the block parks the live stack pointer in the shadow of the mode it is leaving. It loads the shadow of the mode it enters into the live stack pointer in the same edge. While a shadow belongs to the active mode, an access to it goes to the live stack pointer.

Top module: `ctrl_regbank`

## Requirements
- R1: After reset every register is zero, the stack mode is 0 (user), `cond_o` is 0, and every index reads 0.
- R2: A write to index 0 (status word) loads data[15:8] into the backup status, data[7:6] into the current status bits, and data[0] into the condition bit. Reading index 0 returns {16'b0, backup status & 8'hC1, status[7:6], 5'b0, cond}. Status bit 7 is the stack mode (1 = system), visible on `stack_mode_o`.
- R3: A status write that changes the stack mode from 0 to 1 copies the live stack pointer into the user shadow and loads the interrupt shadow into the live stack pointer, in the same edge.
- R4: A status write that changes the stack mode from 1 to 0 copies the live stack pointer into the interrupt shadow and loads the user shadow into the live stack pointer. A status write that leaves the mode unchanged moves no stack pointer.
- R5: Index 2 (interrupt stack pointer) in mode 1, and index 3 (user stack pointer) in mode 0, read and write the live stack pointer. The other of the two reaches its own shadow.
- R6: Index 6 (backup PC) and index 9 (second backup PC) store all 32 written bits and read back with bit 0 forced to 0.
- R7: Index 8 (second backup status) stores data[7:0] and reads back that byte ANDed with 8'hC1, zero-extended.
- R8: A write to index 1 changes only the condition bit, taken from data[0]. Index 1 reads {31'b0, cond}.
- R9: Indices 4 and 5 are plain 32-bit read/write words. Index 5 holds the exception vector base.
- R10: Indices 7 and 10 to 15 read as 0. Writes to them change no register.
- R11: A register-15 side write is dropped when a same-cycle control write moves or writes the live stack pointer (a mode swap, or an active-shadow write). Otherwise it loads the live stack pointer. A swap saves the pre-edge live value.
- R12: `cr_rd_data_o`, `sp_rd_data_o`, `cond_o` and `stack_mode_o` reflect register state combinationally. A write becomes visible only after the next rising edge, so a same-cycle read returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_rd_idx_i | input | 4 | Control-register read index |
| cr_rd_data_o | output | 32 | Read data for `cr_rd_idx_i` |
| cr_wr_en_i | input | 1 | Control-register write enable |
| cr_wr_idx_i | input | 4 | Control-register write index |
| cr_wr_data_i | input | 32 | Control-register write data |
| sp_wr_en_i | input | 1 | Register-15 side write enable |
| sp_wr_data_i | input | 32 | Register-15 side write data |
| sp_rd_data_o | output | 32 | Live stack pointer (register 15) |
| cond_o | output | 1 | Condition bit |
| stack_mode_o | output | 1 | Stack mode, 1 = system |

## Verification
Reads are combinational, so the expected value of a read is due in the same cycle its index is applied. A write is due one rising edge after it is driven, and that includes the stack swap caused by a status write. The driver task applies each stimulus just after a rising edge and queues the expected value with the requirement tag. The monitor pops the queue and compares at the following falling edge, which is after the combinational settle and before the next edge. One check reads a register in the same cycle it is written and expects the old value, which pins the one-edge write latency of R12.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int XLEN  = 32;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] IDX_STATUS = 4'd0;
  localparam logic [IDX_W-1:0] IDX_COND   = 4'd1;
  localparam logic [IDX_W-1:0] IDX_ISP    = 4'd2;
  localparam logic [IDX_W-1:0] IDX_USP    = 4'd3;
  localparam logic [IDX_W-1:0] IDX_BKSTAT = 4'd8;

  // plain 32-bit words: scratch, vector base, backup PC, second backup PC
  localparam int NWORD = 4;

  localparam logic [7:0] STAT_RD_MASK = 8'hC1;

  function automatic logic [IDX_W-1:0] word_idx(int i);
    case (i)
      0:       return 4'd4;
      1:       return 4'd5;
      2:       return 4'd6;
      default: return 4'd9;
    endcase
  endfunction

  function automatic bit word_clr_lsb(int i);
    return (i >= 2);
  endfunction
endpackage

// File: rtl/crb_status.sv
module crb_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stat_i,
  input  logic        wr_cond_i,
  input  logic        wr_bkstat_i,
  input  logic [15:0] wd_i,
  output logic [1:0]  stat_hi_o,
  output logic [7:0]  bstat_o,
  output logic [7:0]  bkstat_o,
  output logic        cond_o,
  output logic        swap_to_sys_o,
  output logic        swap_to_usr_o
);
  logic [1:0] stat_hi_q;
  logic [7:0] bstat_q, bkstat_q;
  logic       cond_q;

  assign swap_to_sys_o = wr_stat_i && !stat_hi_q[1] &&  wd_i[7];
  assign swap_to_usr_o = wr_stat_i &&  stat_hi_q[1] && !wd_i[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_hi_q <= '0;
      bstat_q   <= '0;
      bkstat_q  <= '0;
      cond_q    <= 1'b0;
    end else begin
      if (wr_stat_i) begin
        stat_hi_q <= wd_i[7:6];
        bstat_q   <= wd_i[15:8];
        cond_q    <= wd_i[0];
      end else if (wr_cond_i) begin
        cond_q    <= wd_i[0];
      end
      if (wr_bkstat_i) bkstat_q <= wd_i[7:0];
    end
  end

  assign stat_hi_o = stat_hi_q;
  assign bstat_o   = bstat_q;
  assign bkstat_o  = bkstat_q;
  assign cond_o    = cond_q;

  // R8: condition-register write leaves status bits untouched
  p_cond_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cond_i && !wr_stat_i) |=> ($stable(stat_hi_q) && $stable(bstat_q)));

  // R2: status write lands next edge
  p_stat_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat_i |=> (stat_hi_q == $past(wd_i[7:6]) && cond_q == $past(wd_i[0])));
endmodule

// File: rtl/crb_stack.sv
module crb_stack #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_i,
  input  logic         swap_to_sys_i,
  input  logic         swap_to_usr_i,
  input  logic         wr_isp_i,
  input  logic         wr_usp_i,
  input  logic [W-1:0] wd_i,
  input  logic         side_we_i,
  input  logic [W-1:0] side_wd_i,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] isp_o,
  output logic [W-1:0] usp_o
);
  logic [W-1:0] sp_q, isp_q, usp_q;
  logic         live_wr, cr_touch_live;

  assign live_wr       = (wr_isp_i && mode_i) || (wr_usp_i && !mode_i);
  assign cr_touch_live = live_wr || swap_to_sys_i || swap_to_usr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= '0;
      isp_q <= '0;
      usp_q <= '0;
    end else if (swap_to_sys_i) begin
      usp_q <= sp_q;
      sp_q  <= isp_q;
    end else if (swap_to_usr_i) begin
      isp_q <= sp_q;
      sp_q  <= usp_q;
    end else begin
      if (live_wr)              sp_q  <= wd_i;
      else if (side_we_i)       sp_q  <= side_wd_i;
      if (wr_isp_i && !mode_i)  isp_q <= wd_i;
      if (wr_usp_i &&  mode_i)  usp_q <= wd_i;
    end
  end

  assign sp_o  = sp_q;
  assign isp_o = isp_q;
  assign usp_o = usp_q;

  p_swap_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
    swap_to_sys_i |=> (sp_q == $past(isp_q) && usp_q == $past(sp_q)));

  p_swap_usr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_to_usr_i |=> (sp_q == $past(usp_q) && isp_q == $past(sp_q)));

  p_side_loses_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (side_we_i && live_wr && !swap_to_sys_i && !swap_to_usr_i) |=> sp_q == $past(wd_i));

  p_side_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (side_we_i && !cr_touch_live) |=> sp_q == $past(side_wd_i));
endmodule

// File: rtl/crb_word.sv
module crb_word #(
  parameter int W       = 32,
  parameter bit CLR_LSB = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (we_i) q <= wd_i;
  end

  generate
    if (CLR_LSB) begin : g_clr
      assign rd_o = {q[W-1:1], 1'b0};
    end else begin : g_full
      assign rd_o = q;
    end
  endgenerate
endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
  import crb_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cr_rd_idx_i,
  output logic [W-1:0]  cr_rd_data_o,
  input  logic          cr_wr_en_i,
  input  logic [IW-1:0] cr_wr_idx_i,
  input  logic [W-1:0]  cr_wr_data_i,
  input  logic          sp_wr_en_i,
  input  logic [W-1:0]  sp_wr_data_i,
  output logic [W-1:0]  sp_rd_data_o,
  output logic          cond_o,
  output logic          stack_mode_o
);
  logic        wr_stat, wr_cond, wr_bkstat, wr_isp, wr_usp;
  logic [1:0]  stat_hi;
  logic [7:0]  bstat, bkstat;
  logic        cond, swap_sys, swap_usr, mode;
  logic [W-1:0] sp, isp, usp;
  logic [W-1:0] word_rd [NWORD];

  assign wr_stat   = cr_wr_en_i && (cr_wr_idx_i == IDX_STATUS);
  assign wr_cond   = cr_wr_en_i && (cr_wr_idx_i == IDX_COND);
  assign wr_bkstat = cr_wr_en_i && (cr_wr_idx_i == IDX_BKSTAT);
  assign wr_isp    = cr_wr_en_i && (cr_wr_idx_i == IDX_ISP);
  assign wr_usp    = cr_wr_en_i && (cr_wr_idx_i == IDX_USP);

  crb_status u_status (
    .clk(clk), .rst_n(rst_n),
    .wr_stat_i(wr_stat), .wr_cond_i(wr_cond), .wr_bkstat_i(wr_bkstat),
    .wd_i(cr_wr_data_i[15:0]),
    .stat_hi_o(stat_hi), .bstat_o(bstat), .bkstat_o(bkstat), .cond_o(cond),
    .swap_to_sys_o(swap_sys), .swap_to_usr_o(swap_usr)
  );

  assign mode = stat_hi[1];

  crb_stack #(.W(W)) u_stack (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .swap_to_sys_i(swap_sys), .swap_to_usr_i(swap_usr),
    .wr_isp_i(wr_isp), .wr_usp_i(wr_usp), .wd_i(cr_wr_data_i),
    .side_we_i(sp_wr_en_i), .side_wd_i(sp_wr_data_i),
    .sp_o(sp), .isp_o(isp), .usp_o(usp)
  );

  generate
    for (genvar g = 0; g < NWORD; g++) begin : g_word
      crb_word #(.W(W), .CLR_LSB(word_clr_lsb(g))) u_word (
        .clk(clk), .rst_n(rst_n),
        .we_i(cr_wr_en_i && (cr_wr_idx_i == word_idx(g))),
        .wd_i(cr_wr_data_i),
        .rd_o(word_rd[g])
      );
    end
  endgenerate

  always_comb begin
    cr_rd_data_o = '0;
    case (cr_rd_idx_i)
      IDX_STATUS: cr_rd_data_o = W'({bstat & STAT_RD_MASK, stat_hi, 5'b0, cond});
      IDX_COND:   cr_rd_data_o = W'(cond);
      IDX_ISP:    cr_rd_data_o = mode ? sp : isp;
      IDX_USP:    cr_rd_data_o = mode ? usp : sp;
      IDX_BKSTAT: cr_rd_data_o = W'(bkstat & STAT_RD_MASK);
      default: begin
        for (int i = 0; i < NWORD; i++)
          if (cr_rd_idx_i == word_idx(i)) cr_rd_data_o = word_rd[i];
      end
    endcase
  end

  assign sp_rd_data_o = sp;
  assign cond_o       = cond;
  assign stack_mode_o = mode;

  logic idx_unmapped;
  always_comb begin
    idx_unmapped = !(cr_wr_idx_i inside {IDX_STATUS, IDX_COND, IDX_ISP, IDX_USP, IDX_BKSTAT});
    for (int i = 0; i < NWORD; i++)
      if (cr_wr_idx_i == word_idx(i)) idx_unmapped = 1'b0;
  end

  // R10: unmapped writes change nothing (no side write in the same cycle)
  p_unmapped_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr_en_i && idx_unmapped && !sp_wr_en_i) |=>
      ($stable(sp) && $stable(isp) && $stable(usp) && $stable(bstat) &&
       $stable(bkstat) && $stable(stat_hi) && $stable(cond)));

  // R6: saved program counters never show bit 0
  p_pc_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_rd_idx_i == 4'd6 || cr_rd_idx_i == 4'd9) |-> !cr_rd_data_o[0]);
endmodule

// File: tb/tb_ctrl_regbank.sv
module tb_ctrl_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cr_rd_idx = '0;
  logic [31:0] cr_rd_data;
  logic        cr_wr_en = 1'b0;
  logic [3:0]  cr_wr_idx = '0;
  logic [31:0] cr_wr_data = '0;
  logic        sp_wr_en = 1'b0;
  logic [31:0] sp_wr_data = '0;
  logic [31:0] sp_rd_data;
  logic        cond, mode;

  ctrl_regbank dut (
    .clk(clk), .rst_n(rst_n),
    .cr_rd_idx_i(cr_rd_idx), .cr_rd_data_o(cr_rd_data),
    .cr_wr_en_i(cr_wr_en), .cr_wr_idx_i(cr_wr_idx), .cr_wr_data_i(cr_wr_data),
    .sp_wr_en_i(sp_wr_en), .sp_wr_data_i(sp_wr_data),
    .sp_rd_data_o(sp_rd_data), .cond_o(cond), .stack_mode_o(mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef enum int {K_CR, K_SP, K_COND, K_MODE} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // monitor: compares at the falling edge of the cycle the item was queued in
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = sb.pop_front();
      case (e.kind)
        K_CR:    act = cr_rd_data;
        K_SP:    act = sp_rd_data;
        K_COND:  act = {31'b0, cond};
        default: act = {31'b0, mode};
      endcase
      n_vec++;
      if (act !== e.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", e.tag, act, e.exp);
      end
    end
  end

  // one cycle of stimulus: drive just after posedge, hold to next posedge
  task automatic cyc(input bit cw, input logic [3:0] ci, input logic [31:0] cd,
                     input bit sw, input logic [31:0] sd);
    cr_wr_en = cw; cr_wr_idx = ci; cr_wr_data = cd;
    sp_wr_en = sw; sp_wr_data = sd;
    @(posedge clk); #1;
    cr_wr_en = 1'b0; sp_wr_en = 1'b0;
  endtask

  task automatic crw(input logic [3:0] i, input logic [31:0] d);
    cyc(1'b1, i, d, 1'b0, '0);
  endtask

  task automatic rd(input logic [3:0] i, input logic [31:0] e, input string tag);
    exp_t x;
    cr_rd_idx = i;
    x.kind = K_CR; x.exp = e; x.tag = tag;
    sb.push_back(x);
    @(posedge clk); #1;
  endtask

  task automatic chk(input kind_e k, input logic [31:0] e, input string tag);
    exp_t x;
    x.kind = k; x.exp = e; x.tag = tag;
    sb.push_back(x);
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 16; i++) rd(4'(i), 32'h0, "R1 reset read");
    chk(K_SP, 0, "R1 sp"); chk(K_COND, 0, "R1 cond"); chk(K_MODE, 0, "R1 mode");

    // R11 side write alone, R5 user shadow is live in mode 0
    cyc(1'b0, 0, 0, 1'b1, 32'h1000);
    chk(K_SP, 32'h1000, "R11 side write");
    rd(4'd3, 32'h1000, "R5 usp live in mode 0");
    crw(4'd2, 32'h2000);
    rd(4'd2, 32'h2000, "R5 isp shadow in mode 0");
    chk(K_SP, 32'h1000, "R5 shadow write keeps sp");

    // R2/R3 status write, mode 0 -> 1
    crw(4'd0, 32'h0000_FF81);
    rd(4'd0, 32'h0000_C181, "R2 status layout");
    chk(K_COND, 1, "R2 cond from status");
    chk(K_MODE, 1, "R2 mode bit");
    chk(K_SP, 32'h2000, "R3 sp loaded from isp");
    rd(4'd3, 32'h1000, "R3 usp saved");
    rd(4'd2, 32'h2000, "R5 isp live in mode 1");
    crw(4'd2, 32'h2222);
    chk(K_SP, 32'h2222, "R5 isp write hits sp");

    // R4 mode 1 -> 0
    crw(4'd0, 32'h0000_0040);
    rd(4'd0, 32'h0000_0040, "R2 status second pattern");
    chk(K_SP, 32'h1000, "R4 sp loaded from usp");
    rd(4'd2, 32'h2222, "R4 isp saved");

    // R8 condition register
    crw(4'd1, 32'hFFFF_FFFE);
    chk(K_COND, 0, "R8 cond clear");
    crw(4'd1, 32'h0000_0003);
    rd(4'd1, 32'h1, "R8 cond read");
    rd(4'd0, 32'h0000_0041, "R8 status unchanged by cond write");

    // R4 no swap when mode unchanged
    crw(4'd0, 32'h0000_0001);
    chk(K_SP, 32'h1000, "R4 no swap same mode");
    rd(4'd0, 32'h1, "R2 status third pattern");

    // R6 saved PCs
    crw(4'd6, 32'h1234_5679);
    rd(4'd6, 32'h1234_5678, "R6 bpc lsb cleared");
    crw(4'd9, 32'hFFFF_FFFF);
    rd(4'd9, 32'hFFFF_FFFE, "R6 bbpc lsb cleared");

    // R7 second backup status
    crw(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, 32'h0000_00C1, "R7 bkstat mask");
    crw(4'd8, 32'h0000_003E);
    rd(4'd8, 32'h0, "R7 bkstat masked bits");

    // R9 plain words
    crw(4'd4, 32'hDEAD_BEEF);
    crw(4'd5, 32'h0BAD_F00D);
    rd(4'd4, 32'hDEAD_BEEF, "R9 word 4");
    rd(4'd5, 32'h0BAD_F00D, "R9 word 5 vector base");

    // R10 unmapped indices
    crw(4'd7, 32'hFFFF_FFFF);
    crw(4'd15, 32'hFFFF_FFFF);
    rd(4'd7, 0, "R10 idx 7 reads 0");
    rd(4'd15, 0, "R10 idx 15 reads 0");
    rd(4'd4, 32'hDEAD_BEEF, "R10 word 4 untouched");
    rd(4'd0, 32'h1, "R10 status untouched");
    rd(4'd2, 32'h2222, "R10 isp untouched");
    chk(K_SP, 32'h1000, "R10 sp untouched");

    // R12 same-cycle read returns old value
    cr_rd_idx = 4'd4;
    begin
      exp_t x;
      x.kind = K_CR; x.exp = 32'hDEAD_BEEF; x.tag = "R12 old value in write cycle";
      sb.push_back(x);
    end
    crw(4'd4, 32'h1111_1111);
    rd(4'd4, 32'h1111_1111, "R12 new value after edge");

    // R11 priorities
    cyc(1'b1, 4'd3, 32'h5555, 1'b1, 32'h7777);
    chk(K_SP, 32'h5555, "R11 active-shadow write beats side");
    cyc(1'b1, 4'd2, 32'h6666, 1'b1, 32'h8888);
    chk(K_SP, 32'h8888, "R11 inactive-shadow write lets side in");
    rd(4'd2, 32'h6666, "R11 isp shadow written");
    cyc(1'b1, 4'd0, 32'h0000_0080, 1'b1, 32'h9999);
    chk(K_SP, 32'h6666, "R11 swap beats side");
    rd(4'd3, 32'h8888, "R11 swap saves pre-edge sp");

    @(posedge clk); #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule